// File: doc/BRIEF.md
# One-Tap CMA Polarization Demultiplexer

This block separates the two polarization tributaries of a coherent receiver after dispersion has been compensated. It takes one pair of complex samples per symbol, one from the X channel and one from the Y channel, each marked by a valid strobe. It mixes them through a 2×2 complex butterfly that has a single coefficient on each of its four paths. The result is one demultiplexed complex pair per accepted input. No output uses neighbouring samples, so the block needs no delay line and runs at one sample per symbol.

After every output pair the block adapts its four complex coefficients by the constant-modulus rule. Each output polarization has its own error term, one minus the squared magnitude of that output. The update gain is four times a step size, and the step size is set by a programmable arithmetic right shift instead of a multiplier. Reset starts the block from the identity matrix, so the first sample passes straight through.

Data samples are signed DW-bit values with DW−2 fraction bits, so 1.0 is 2^(DW−2) (1024 at DW=12). Coefficients are signed CW-bit values with CW−2 fraction bits, so 1.0 is 2^(CW−2) (65536 at CW=18). Index convention: F_ab couples input polarization a into output polarization b.

Top module: `pol_demux_cma`

## Requirements
- R1: out_valid is high in exactly the cycle after a cycle in which in_valid was sampled high, so the latency is one clock. While no sample is accepted, the four output words keep their last value.
- R2: While rst_n is low at a clock edge, out_valid and all output words become 0. Fxx and Fyy load 1.0 and Fxy and Fyx load 0. The first sample after reset therefore leaves the block unchanged (outX = inX, outY = inY).
- R3: outX = Fxx·inX + Fyx·inY and outY = Fxy·inX + Fyy·inY, in complex arithmetic. Each full-precision sum is shifted arithmetically right by CW−2, which rounds toward minus infinity.
- R4: Each output real or imaginary part that exceeds the DW-bit signed range is clipped to 2^(DW−1)−1 or −2^(DW−1).
- R5: The error of output b is 2^(2(DW−2)) − (re_b² + im_b²), computed from the clipped output. It is computed separately for X and for Y.
- R6: For each accepted sample, F_ab becomes F_ab + ((err_b · out_b · conj(in_a)) >>> (4(DW−2) − (CW−2) − 2 + mu_shift)). The shift is arithmetic and the arithmetic is exact before the shift. This equals 4·μ·ε·out·conj(in) with μ = 2^−mu_shift.
- R7: The update from sample k is applied at the clock edge after sample k is filtered. A sample accepted in the very next cycle still uses the old coefficients. Any later sample uses the updated ones.
- R8: An updated coefficient part that leaves the CW-bit signed range is clipped to 2^(CW−1)−1 or −2^(CW−1). This holds in both directions.
- R9: Cycles with in_valid low change no coefficient, whatever values are on the data inputs.
- R10: mu_shift takes any value from 0 to 15 and is read at the edge where the update is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mu_shift | input | MUW (4) | Step-size shift amount |
| in_valid | input | 1 | Input pair valid |
| in_x_re | input | DW (12) | X input, real part |
| in_x_im | input | DW (12) | X input, imaginary part |
| in_y_re | input | DW (12) | Y input, real part |
| in_y_im | input | DW (12) | Y input, imaginary part |
| out_valid | output | 1 | Output pair valid |
| out_x_re | output | DW (12) | X output, real part |
| out_x_im | output | DW (12) | X output, imaginary part |
| out_y_re | output | DW (12) | Y output, real part |
| out_y_im | output | DW (12) | Y output, imaginary part |

## Verification
The coefficients cannot be read directly. Any wrong update therefore shows up as a wrong output word on the second accepted sample after the sample that caused it, or on the next sample if the bench leaves a gap. It then stays wrong for every later sample, because the error feeds back into all following updates. The bench keeps its own fixed-point model of the four coefficients and compares every output word in every cycle. It also drives the coefficients deliberately into both clip limits, so that the clipped values appear at the outputs as exact, predictable numbers.

// File: rtl/pdm_cma_pkg.sv
// Package: shared constants and the tap index map for the one-tap
// polarization demultiplexer. Assumes two polarizations.
package pdm_cma_pkg;
    localparam int NUM_POL  = 2;
    localparam int NUM_TAPS = NUM_POL * NUM_POL;

    // Coefficient slot for input polarization a feeding output polarization b.
    function automatic int tap_index(input int a, input int b);
        return b * NUM_POL + a;
    endfunction
endpackage

// File: rtl/pdm_tap_pair.sv
// Module: two complex one-tap products summed, scaled to the data format
// and clipped. Purely combinational. Assumes coefficient fraction = CW-2.
module pdm_tap_pair #(
    parameter int DW = 12,
    parameter int CW = 18
) (
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [CW-1:0] ca_re,
    input  logic signed [CW-1:0] ca_im,
    input  logic signed [CW-1:0] cb_re,
    input  logic signed [CW-1:0] cb_im,
    output logic signed [DW-1:0] y_re,
    output logic signed [DW-1:0] y_im
);
    localparam int FC = CW - 2;
    localparam int SW = DW + CW + 2;
    localparam logic signed [SW-1:0] YMAX = (SW'(1) <<< (DW - 1)) - SW'(1);
    localparam logic signed [SW-1:0] YMIN = -(SW'(1) <<< (DW - 1));

    logic signed [SW-1:0] acc_re, acc_im, sh_re, sh_im;

    function automatic logic signed [DW-1:0] clip(input logic signed [SW-1:0] v);
        if (v > YMAX)      return YMAX[DW-1:0];
        else if (v < YMIN) return YMIN[DW-1:0];
        else               return v[DW-1:0];
    endfunction

    // Full-precision complex multiply-add, then scale and clip.
    always_comb begin
        acc_re = SW'(ca_re) * SW'(a_re) - SW'(ca_im) * SW'(a_im)
               + SW'(cb_re) * SW'(b_re) - SW'(cb_im) * SW'(b_im);
        acc_im = SW'(ca_re) * SW'(a_im) + SW'(ca_im) * SW'(a_re)
               + SW'(cb_re) * SW'(b_im) + SW'(cb_im) * SW'(b_re);
        sh_re  = acc_re >>> FC;
        sh_im  = acc_im >>> FC;
        y_re   = clip(sh_re);
        y_im   = clip(sh_im);
    end
endmodule

// File: rtl/pdm_err.sv
// Module: constant-modulus error of one output, 1.0 minus squared
// magnitude, in the squared data scale. Combinational.
module pdm_err #(
    parameter int DW = 12
) (
    input  logic signed [DW-1:0]   o_re,
    input  logic signed [DW-1:0]   o_im,
    output logic signed [2*DW+1:0] err
);
    localparam int FD = DW - 2;
    localparam int EW = 2 * DW + 2;

    // Unit modulus minus power of the output sample.
    always_comb begin
        err = (EW'(1) <<< (2 * FD)) - (EW'(o_re) * EW'(o_re) + EW'(o_im) * EW'(o_im));
    end
endmodule

// File: rtl/pdm_coef_upd.sv
// Module: one complex coefficient register with its constant-modulus
// update and clipping. Assumes err, output and input come from the same
// sample and are stable during the cycle where upd is high.
module pdm_coef_upd #(
    parameter int DW       = 12,
    parameter int CW       = 18,
    parameter int MUW      = 4,
    parameter bit INIT_ONE = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   upd,
    input  logic [MUW-1:0]         shift,
    input  logic signed [2*DW+1:0] err,
    input  logic signed [DW-1:0]   ob_re,
    input  logic signed [DW-1:0]   ob_im,
    input  logic signed [DW-1:0]   ia_re,
    input  logic signed [DW-1:0]   ia_im,
    output logic signed [CW-1:0]   c_re,
    output logic signed [CW-1:0]   c_im
);
    localparam int FD   = DW - 2;
    localparam int FC   = CW - 2;
    localparam int EW   = 2 * DW + 2;
    localparam int GW   = 2 * DW + 1;
    localparam int UW   = EW + GW;
    localparam int BASE = 4 * FD - FC - 2;
    localparam logic signed [UW-1:0] CMAX = (UW'(1) <<< (CW - 1)) - UW'(1);
    localparam logic signed [UW-1:0] CMIN = -(UW'(1) <<< (CW - 1));
    localparam logic signed [CW-1:0] RST_RE = INIT_ONE ? (CW'(1) <<< FC) : '0;

    logic signed [GW-1:0] g_re, g_im;
    logic signed [UW-1:0] st_re, st_im, sum_re, sum_im;
    logic signed [CW-1:0] nxt_re, nxt_im;

    function automatic logic signed [CW-1:0] clip(input logic signed [UW-1:0] v);
        if (v > CMAX)      return CMAX[CW-1:0];
        else if (v < CMIN) return CMIN[CW-1:0];
        else               return v[CW-1:0];
    endfunction

    // Gradient out_b * conj(in_a), weighted by the error and shifted by the step.
    always_comb begin
        g_re   = GW'(ob_re) * GW'(ia_re) + GW'(ob_im) * GW'(ia_im);
        g_im   = GW'(ob_im) * GW'(ia_re) - GW'(ob_re) * GW'(ia_im);
        st_re  = (UW'(err) * UW'(g_re)) >>> (BASE + int'(shift));
        st_im  = (UW'(err) * UW'(g_im)) >>> (BASE + int'(shift));
        sum_re = UW'(c_re) + st_re;
        sum_im = UW'(c_im) + st_im;
        nxt_re = clip(sum_re);
        nxt_im = clip(sum_im);
    end

    // Coefficient register: identity value on reset, update only on upd.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_re <= RST_RE;
            c_im <= '0;
        end else if (upd) begin
            c_re <= nxt_re;
            c_im <= nxt_im;
        end
    end
endmodule

// File: rtl/pol_demux_cma.sv
// Module: top of the one-tap butterfly CMA polarization demultiplexer.
// Filters each valid input pair with the current coefficients into a
// registered output (latency OUT_LATENCY). The next cycle adapts all four
// coefficients from that registered pair. Assumes one sample per symbol.
module pol_demux_cma #(
    parameter int DW  = 12,
    parameter int CW  = 18,
    parameter int MUW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MUW-1:0]       mu_shift,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_x_re,
    input  logic signed [DW-1:0] in_x_im,
    input  logic signed [DW-1:0] in_y_re,
    input  logic signed [DW-1:0] in_y_im,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_x_re,
    output logic signed [DW-1:0] out_x_im,
    output logic signed [DW-1:0] out_y_re,
    output logic signed [DW-1:0] out_y_im
);
    import pdm_cma_pkg::*;

    localparam int OUT_LATENCY = 1;
    localparam int EW = 2 * DW + 2;

    logic signed [DW-1:0] xin_re [NUM_POL];
    logic signed [DW-1:0] xin_im [NUM_POL];
    logic signed [DW-1:0] filt_re [NUM_POL];
    logic signed [DW-1:0] filt_im [NUM_POL];
    logic signed [DW-1:0] inq_re [NUM_POL];
    logic signed [DW-1:0] inq_im [NUM_POL];
    logic signed [DW-1:0] outq_re [NUM_POL];
    logic signed [DW-1:0] outq_im [NUM_POL];
    logic signed [EW-1:0] err_b [NUM_POL];
    logic signed [CW-1:0] c_re [NUM_TAPS];
    logic signed [CW-1:0] c_im [NUM_TAPS];
    logic                 vld_q;

    // Gather the input ports into per-polarization arrays.
    always_comb begin
        xin_re[0] = in_x_re;
        xin_im[0] = in_x_im;
        xin_re[1] = in_y_re;
        xin_im[1] = in_y_im;
    end

    for (genvar b = 0; b < NUM_POL; b++) begin : g_out
        localparam int KA = tap_index(0, b);
        localparam int KB = tap_index(1, b);

        pdm_tap_pair #(.DW(DW), .CW(CW)) u_tap (
            .a_re(xin_re[0]), .a_im(xin_im[0]),
            .b_re(xin_re[1]), .b_im(xin_im[1]),
            .ca_re(c_re[KA]), .ca_im(c_im[KA]),
            .cb_re(c_re[KB]), .cb_im(c_im[KB]),
            .y_re(filt_re[b]), .y_im(filt_im[b])
        );

        pdm_err #(.DW(DW)) u_err (
            .o_re(outq_re[b]), .o_im(outq_im[b]), .err(err_b[b])
        );

        for (genvar a = 0; a < NUM_POL; a++) begin : g_in
            localparam int K = tap_index(a, b);
            pdm_coef_upd #(
                .DW(DW), .CW(CW), .MUW(MUW), .INIT_ONE(a == b)
            ) u_coef (
                .clk(clk), .rst_n(rst_n), .upd(vld_q), .shift(mu_shift),
                .err(err_b[b]),
                .ob_re(outq_re[b]), .ob_im(outq_im[b]),
                .ia_re(inq_re[a]), .ia_im(inq_im[a]),
                .c_re(c_re[K]), .c_im(c_im[K])
            );
        end
    end

    // Output and update-stage registers: capture on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            for (int p = 0; p < NUM_POL; p++) begin
                inq_re[p]  <= '0;
                inq_im[p]  <= '0;
                outq_re[p] <= '0;
                outq_im[p] <= '0;
            end
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                for (int p = 0; p < NUM_POL; p++) begin
                    inq_re[p]  <= xin_re[p];
                    inq_im[p]  <= xin_im[p];
                    outq_re[p] <= filt_re[p];
                    outq_im[p] <= filt_im[p];
                end
            end
        end
    end

    // Drive the output ports from the registered stage.
    always_comb begin
        out_valid = vld_q;
        out_x_re  = outq_re[0];
        out_x_im  = outq_im[0];
        out_y_re  = outq_re[1];
        out_y_im  = outq_im[1];
    end
endmodule

// File: rtl/pol_demux_cma_chk.sv
// Checker: port-level timing and reset properties of pol_demux_cma,
// attached by bind. Tracks whether a sample arrived since reset.
module pol_demux_cma_chk #(
    parameter int DW = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic signed [DW-1:0] in_x_re,
    input logic signed [DW-1:0] in_x_im,
    input logic signed [DW-1:0] in_y_re,
    input logic signed [DW-1:0] in_y_im,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_x_re,
    input logic signed [DW-1:0] out_x_im,
    input logic signed [DW-1:0] out_y_re,
    input logic signed [DW-1:0] out_y_im
);
    logic fresh;

    // Marks that no sample has been accepted since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        fresh <= 1'b1;
        else if (in_valid) fresh <= 1'b0;
    end

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_x_re) && $stable(out_x_im)
                       && $stable(out_y_re) && $stable(out_y_im)));

    p_reset_quiet_r2: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_x_re == '0 && out_x_im == '0
                    && out_y_re == '0 && out_y_im == '0));

    p_identity_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fresh && in_valid) |=> (out_x_re == $past(in_x_re) && out_x_im == $past(in_x_im)
                                 && out_y_re == $past(in_y_re) && out_y_im == $past(in_y_im)));
endmodule

bind pol_demux_cma pol_demux_cma_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_x_re(in_x_re), .in_x_im(in_x_im), .in_y_re(in_y_re), .in_y_im(in_y_im),
    .out_valid(out_valid),
    .out_x_re(out_x_re), .out_x_im(out_x_im), .out_y_re(out_y_re), .out_y_im(out_y_im)
);

// File: tb/tb_pol_demux_cma.sv
module tb_pol_demux_cma;
    localparam int DW = 12;
    localparam int CW = 18;
    localparam int MUW = 4;
    localparam longint UNIT2 = longint'(1) <<< (2 * (DW - 2));
    localparam int FCB = CW - 2;
    localparam int BASE = 4 * (DW - 2) - (CW - 2) - 2;

    // Stimulus rows: x_re, x_im, y_re, y_im, idle-cycle-before flag.
    localparam int VEC [16][5] = '{
        '{ 700,  300, -200,  150, 0}, '{-650,  420,  310,  -90, 0},
        '{ 512, -512,  256,  256, 1}, '{-900, -100,   50,  600, 0},
        '{ 100,  800, -700, -300, 0}, '{ 333, -444,  555, -111, 1},
        '{-1024,   0,    0, 1024, 0}, '{2047, -2048,  10,  -10, 0},
        '{-2048, 2047, -2048, 2047, 1}, '{ 64,  -64,  900,  900, 0},
        '{ 720,  -15, -600,  410, 0}, '{-123,  456, -789,  321, 1},
        '{   5,   -7,   11,  -13, 0}, '{ 999,  888, -777, -666, 0},
        '{-300, -300,  300,  300, 1}, '{ 640,  480,  320,  240, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [MUW-1:0] mu_shift = '0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_x_re = '0, in_x_im = '0, in_y_re = '0, in_y_im = '0;
    logic out_valid;
    logic signed [DW-1:0] out_x_re, out_x_im, out_y_re, out_y_im;

    int n_checks = 0;
    int n_fail = 0;
    int cyc_cnt = 0;

    longint mc_re [4], mc_im [4];
    bit     pend, e_vld;
    longint p_in_re [2], p_in_im [2], p_out_re [2], p_out_im [2];
    longint e_re [2], e_im [2];

    always #5 clk = ~clk;

    pol_demux_cma #(.DW(DW), .CW(CW), .MUW(MUW)) dut (
        .clk(clk), .rst_n(rst_n), .mu_shift(mu_shift), .in_valid(in_valid),
        .in_x_re(in_x_re), .in_x_im(in_x_im), .in_y_re(in_y_re), .in_y_im(in_y_im),
        .out_valid(out_valid),
        .out_x_re(out_x_re), .out_x_im(out_x_im), .out_y_re(out_y_re), .out_y_im(out_y_im)
    );

    function automatic longint clipw(longint v, int w);
        longint hi = (longint'(1) <<< (w - 1)) - 1;
        if (v > hi) return hi;
        if (v < -hi - 1) return -hi - 1;
        return v;
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 4; k++) begin
            mc_re[k] = (k == 0 || k == 3) ? (longint'(1) <<< FCB) : 0;
            mc_im[k] = 0;
        end
        pend = 0; e_vld = 0;
        for (int p = 0; p < 2; p++) begin
            e_re[p] = 0; e_im[p] = 0;
        end
    endtask

    // One clock edge of the reference: filter with old coefficients, then apply pending update.
    task automatic model_step(bit v, longint xr, longint xi, longint yr, longint yi, int mu);
        longint ir [2], ii [2], nr [2], ni [2];
        ir[0] = xr; ii[0] = xi; ir[1] = yr; ii[1] = yi;
        for (int b = 0; b < 2; b++) begin
            nr[b] = clipw((mc_re[2*b]*ir[0] - mc_im[2*b]*ii[0]
                         + mc_re[2*b+1]*ir[1] - mc_im[2*b+1]*ii[1]) >>> FCB, DW);
            ni[b] = clipw((mc_re[2*b]*ii[0] + mc_im[2*b]*ir[0]
                         + mc_re[2*b+1]*ii[1] + mc_im[2*b+1]*ir[1]) >>> FCB, DW);
        end
        if (pend) begin
            for (int b = 0; b < 2; b++) begin
                for (int a = 0; a < 2; a++) begin
                    longint er, gr, gi;
                    int k;
                    k  = 2 * b + a;
                    er = UNIT2 - (p_out_re[b]*p_out_re[b] + p_out_im[b]*p_out_im[b]);
                    gr = p_out_re[b]*p_in_re[a] + p_out_im[b]*p_in_im[a];
                    gi = p_out_im[b]*p_in_re[a] - p_out_re[b]*p_in_im[a];
                    mc_re[k] = clipw(mc_re[k] + ((er * gr) >>> (BASE + mu)), CW);
                    mc_im[k] = clipw(mc_im[k] + ((er * gi) >>> (BASE + mu)), CW);
                end
            end
        end
        pend = v;
        e_vld = v;
        if (v) begin
            for (int p = 0; p < 2; p++) begin
                p_in_re[p] = ir[p]; p_in_im[p] = ii[p];
                p_out_re[p] = nr[p]; p_out_im[p] = ni[p];
                e_re[p] = nr[p]; e_im[p] = ni[p];
            end
        end
    endtask

    // Drive one cycle from a falling edge and compare all outputs at the next falling edge.
    task automatic cycle(bit v, int xr, int xi, int yr, int yi, string req);
        in_valid = v;
        in_x_re = DW'(xr); in_x_im = DW'(xi); in_y_re = DW'(yr); in_y_im = DW'(yi);
        model_step(v, xr, xi, yr, yi, int'(mu_shift));
        @(posedge clk);
        @(negedge clk);
        check(req, "out_valid", longint'(out_valid), longint'(e_vld));
        check(req, "out_x_re", out_x_re, e_re[0]);
        check(req, "out_x_im", out_x_im, e_im[0]);
        check(req, "out_y_re", out_y_re, e_re[1]);
        check(req, "out_y_im", out_y_im, e_im[1]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_x_re = 12'sd77; in_x_im = -12'sd5; in_y_re = 12'sd9; in_y_im = 12'sd1;
        repeat (3) @(negedge clk);
        model_reset();
        check("R2", "reset out_valid", longint'(out_valid), 0);
        check("R2", "reset out_x_re", out_x_re, 0);
        check("R2", "reset out_y_im", out_y_im, 0);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc_cnt);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R2 identity start and R7 stale coefficients on the next back-to-back sample.
        mu_shift = 4'd4;
        cycle(1, 300, -200, 50, 75, "R2");
        check("R2", "first x_re passes", out_x_re, 300);
        check("R2", "first y_im passes", out_y_im, 75);
        cycle(1, -400, 100, 20, -30, "R7");
        check("R7", "second x_re still identity", out_x_re, -400);
        check("R7", "second y_re still identity", out_y_re, 20);
        cycle(1, 500, 250, -125, 60, "R7");

        // Table walk: filtering, error and update under mixed patterns (R3, R5, R6).
        mu_shift = 4'd3;
        for (int i = 0; i < 16; i++) begin
            if (VEC[i][4] != 0) cycle(0, 0, 0, 0, 0, "R1");
            cycle(1, VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], "R6");
        end

        // R9: idle cycles with busy data inputs must not move coefficients.
        for (int i = 0; i < 4; i++) cycle(0, 1500 - i, -1700, 900, 2000, "R9");
        cycle(1, 410, -220, 180, 90, "R9");
        cycle(0, -2048, 2047, -2048, 2047, "R9");
        cycle(1, 410, -220, 180, 90, "R9");

        // R10: extreme step shifts.
        mu_shift = 4'd0;
        for (int i = 0; i < 6; i++) cycle(1, 600 - 50*i, 200, -300, 100 + 40*i, "R10");
        mu_shift = 4'd15;
        for (int i = 0; i < 6; i++) cycle(1, -800, 30*i, 450, -250, "R10");

        // R3 and R5 on a clean start with moderate X-only input.
        do_reset();
        mu_shift = 4'd2;
        for (int i = 0; i < 8; i++) cycle(1, 700, -300, 0, 0, "R5");

        // R8 and R4: grow Fxx to its upper clip, then push it through the lower clip.
        do_reset();
        mu_shift = 4'd0;
        for (int i = 0; i < 60; i++) cycle(1, 100, 0, 0, 0, "R8");
        cycle(1, 2047, 0, 0, 0, "R4");
        check("R4", "clipped x_re", out_x_re, 2047);
        cycle(1, 1000, 0, 0, 0, "R8");
        check("R8", "x_re from upper-clipped Fxx", out_x_re, 1999);
        cycle(1, 1000, 0, 0, 0, "R8");
        check("R8", "x_re from lower-clipped Fxx", out_x_re, -2000);
        check("R3", "y_re stays zero without cross terms", out_y_re, 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule